// File: doc/BRIEF.md
# Character LCD Controller over an I2C Port Expander

This block drives a 4-bit character LCD whose pins hang off an 8-bit I2C port expander. Every LCD byte is cut into a high and a low nibble, and each nibble goes out as two expander writes. The first write has the enable strobe high and the second has it low, so the LCD latches on the falling edge. The controller does not drive SCL or SDA itself. It hands one-byte write requests to a separate I2C master and waits for that master to report each one finished.

After reset the block runs the LCD power-up sequence on its own. It waits, switches the LCD into 4-bit mode, configures it, clears it, waits again and sets the entry mode. Only then does it take traffic. Two input streams exist. One carries single command or character bytes. The other carries a string of characters aimed at one line of a 4-line display. For a string, the block moves the LCD address to the start of the chosen line before the first character. All waits are counted in clock cycles derived from the clock frequency parameter.

Top module: `charlcd_exp_ctrl`

## Requirements
- R1: Out of reset `req_valid`, `cmd_ready`, `str_ready`, `init_done` and `err_flag` are all 0. No expander write is requested until the power-up wait of PWR_US microseconds has elapsed. Neither input stream is accepted before `init_done` is 1.
- R2: The power-up sequence is exactly: the lone nibble 0x2, then bytes 0x28, 0x0C and 0x01, then a wait of at least CLR_US microseconds, then byte 0x06, after which `init_done` rises.
- R3: Each expander data byte is laid out as bit 0 register select, bit 1 read/write, bit 2 enable, bit 3 backlight, and bits 7..4 the LCD data nibble.
- R4: A nibble is sent as two writes with identical data and flags: first enable=1, then enable=0. A byte sends its high nibble before its low nibble (four writes).
- R5: Register select is 0 for command bytes and 1 for character bytes (`cmd_is_char`=1, or any string character). Read/write is always 0.
- R6: The backlight bit is 0 in every write up to and including the power-up sequence, and 1 in every write after `init_done` rises.
- R7: `req_addr` is 0x4E. A request stays asserted with stable data until `req_done` or `req_err`, and the next write is issued only after `req_done`.
- R8: A string starts with the line number taken from `str_line` while the first character is pending. After a wait of at least LINE_US microseconds the block sends command 0x80 OR the line base (0, 64, 20, 84 for lines 0..3). It then sends each character in order until the one flagged `str_last`. `str_line` on later characters is ignored.
- R9: `req_err` sets `err_flag`, which stays set until reset. It abandons the remaining writes of the current byte, and the next byte is then sent in full.
- R10: Command bytes are accepted only in the idle state, so `cmd_ready` stays 0 while a string is in progress. `cmd_ready` and `str_ready` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A single byte is offered |
| cmd_ready | output | 1 | Single byte accepted this cycle when valid |
| cmd_byte | input | 8 | Byte to send to the LCD |
| cmd_is_char | input | 1 | 1 = display character, 0 = LCD command |
| str_valid | input | 1 | A string character is offered |
| str_ready | output | 1 | String character accepted this cycle when valid |
| str_line | input | 2 | Target line, used while the first character is pending |
| str_char | input | 8 | String character |
| str_last | input | 1 | Marks the final character of the string |
| req_valid | output | 1 | Expander write request to the I2C master |
| req_addr | output | 8 | Expander bus address byte (write) |
| req_data | output | 8 | Expander data byte |
| req_done | input | 1 | One-cycle pulse: request completed |
| req_err | input | 1 | One-cycle pulse: request failed (NACK or bus error) |
| init_done | output | 1 | Power-up sequence finished |
| err_flag | output | 1 | Sticky error indication |

## Verification
The hardest situation to reach from the ports is a failure in the middle of a byte. The error must land after the enable-high write of a nibble but before the rest, so the abort path and the resumption of the next byte can be observed. The bench's I2C master model takes a frame index at which to answer with an error instead of completion. The index is aimed at the second write of a chosen byte, and the logged frames then show the truncated byte followed by a complete one. The waits are reached by building the design at a 1 MHz clock, so each microsecond is one cycle. The start time of every logged request is then compared against the required minimum gap.

// File: rtl/charlcd_exp_pkg.sv
// Shared definitions for the expander-driven character LCD controller.
// Assumes a 4-bit LCD wired to the expander with data on bits 7..4.
package charlcd_exp_pkg;

    // Expander bit positions, decoded by the board wiring
    localparam int unsigned BIT_RS = 0;
    localparam int unsigned BIT_RW = 1;
    localparam int unsigned BIT_EN = 2;
    localparam int unsigned BIT_BL = 3;

    // LCD command bytes used by the power-up sequence
    localparam logic [7:0] LCD_NIB_4BIT  = 8'h02;
    localparam logic [7:0] LCD_FUNC_SET  = 8'h28;
    localparam logic [7:0] LCD_DISP_CTRL = 8'h0C;
    localparam logic [7:0] LCD_CLEAR     = 8'h01;
    localparam logic [7:0] LCD_ENTRY     = 8'h06;
    localparam logic [7:0] LCD_SET_ADDR  = 8'h80;

    typedef enum logic [3:0] {
        SQ_PWR, SQ_NIB, SQ_FUNC, SQ_DISP, SQ_CLR, SQ_CLRW, SQ_ENTRY,
        SQ_IDLE, SQ_BYTE, SQ_LWAIT, SQ_LADDR, SQ_RUN, SQ_CHAR
    } seq_t;

    // Start address of a display line on a 4-line panel
    function automatic logic [7:0] line_base(input logic [1:0] line);
        case (line)
            2'd0:    return 8'd0;
            2'd1:    return 8'd64;
            2'd2:    return 8'd20;
            default: return 8'd84;
        endcase
    endfunction

endpackage

// File: rtl/charlcd_exp_wait.sv
// Down-counting delay timer. Loads a cycle count and reports expiry once it
// reaches zero. Starts out loaded with RST_VAL so a power-up wait needs no trigger.
module charlcd_exp_wait #(
    parameter int unsigned W       = 21,
    parameter int unsigned RST_VAL = 100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Count down towards zero, reload on request
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= W'(RST_VAL);
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/charlcd_exp_byte_tx.sv
// Turns one LCD byte (or a lone low nibble) into expander write requests:
// per nibble an enable-high frame then an enable-low frame, high nibble first.
// Assumes the master pulses done or err once per request. An err ends the byte.
module charlcd_exp_byte_tx
    import charlcd_exp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] byte_in,
    input  logic       rs_in,
    input  logic       nib_only,
    input  logic       backlight,
    output logic       busy,
    output logic       done,
    output logic [7:0] frame,
    input  logic       req_done,
    input  logic       req_err
);
    logic [1:0] idx;     // bit 1: low nibble, bit 0: enable-low half
    logic [7:0] byte_q;
    logic       rs_q;
    logic [3:0] nib;

    // Frame step counter and byte latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            idx    <= 2'd0;
            byte_q <= 8'h00;
            rs_q   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy   <= 1'b1;
                    idx    <= nib_only ? 2'd2 : 2'd0;
                    byte_q <= byte_in;
                    rs_q   <= rs_in;
                end
            end else if (req_err) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else if (req_done) begin
                if (idx == 2'd3) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + 2'd1;
                end
            end
        end
    end

    // Assemble the expander data byte for the current step
    always_comb begin
        nib           = idx[1] ? byte_q[3:0] : byte_q[7:4];
        frame         = {nib, 4'b0000};
        frame[BIT_RS] = rs_q;
        frame[BIT_RW] = 1'b0;
        frame[BIT_EN] = ~idx[0];
        frame[BIT_BL] = backlight;
    end
endmodule

// File: rtl/charlcd_exp_ctrl.sv
// Character LCD controller through an I2C port expander.
// Runs the LCD power-up sequence, then serves single bytes and line strings.
// Assumes an external I2C master that writes req_data to address req_addr and
// answers each request with a single-cycle req_done or req_err.
module charlcd_exp_ctrl
    import charlcd_exp_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 48_000_000,
    parameter int unsigned PWR_US   = 40_000,
    parameter int unsigned CLR_US   = 2_000,
    parameter int unsigned LINE_US  = 50,
    parameter logic [7:0]  EXP_ADDR = 8'h4E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [7:0] cmd_byte,
    input  logic       cmd_is_char,
    input  logic       str_valid,
    output logic       str_ready,
    input  logic [1:0] str_line,
    input  logic [7:0] str_char,
    input  logic       str_last,
    output logic       req_valid,
    output logic [7:0] req_addr,
    output logic [7:0] req_data,
    input  logic       req_done,
    input  logic       req_err,
    output logic       init_done,
    output logic       err_flag
);
    localparam int unsigned CYC_US   = (CLK_HZ < 1_000_000) ? 1 : CLK_HZ / 1_000_000;
    localparam int unsigned PWR_CYC  = CYC_US * PWR_US;
    localparam int unsigned CLR_CYC  = CYC_US * CLR_US;
    localparam int unsigned LINE_CYC = CYC_US * LINE_US;
    localparam int unsigned MAX_A    = (PWR_CYC > CLR_CYC) ? PWR_CYC : CLR_CYC;
    localparam int unsigned MAX_CYC  = (MAX_A > LINE_CYC) ? MAX_A : LINE_CYC;
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

    seq_t             st, nxt;
    logic             go, g_rs, g_nib, ld;
    logic [7:0]       g_byte;
    logic [CNT_W-1:0] ld_val;
    logic             expired, eng_busy, eng_done;
    logic [1:0]       line_q;
    logic             last_q, init_q, err_q;

    charlcd_exp_wait #(.W(CNT_W), .RST_VAL(PWR_CYC)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .expired(expired)
    );

    charlcd_exp_byte_tx u_tx (
        .clk(clk), .rst_n(rst_n), .start(go), .byte_in(g_byte), .rs_in(g_rs),
        .nib_only(g_nib), .backlight(init_q), .busy(eng_busy), .done(eng_done),
        .frame(req_data), .req_done(req_done), .req_err(req_err)
    );

    // Sequencer: next state plus the byte launched or the wait loaded on each step
    always_comb begin
        nxt    = st;
        go     = 1'b0;
        g_byte = 8'h00;
        g_rs   = 1'b0;
        g_nib  = 1'b0;
        ld     = 1'b0;
        ld_val = '0;
        case (st)
            SQ_PWR:   if (expired) begin go = 1'b1; g_byte = LCD_NIB_4BIT; g_nib = 1'b1; nxt = SQ_NIB; end
            SQ_NIB:   if (eng_done) begin go = 1'b1; g_byte = LCD_FUNC_SET; nxt = SQ_FUNC; end
            SQ_FUNC:  if (eng_done) begin go = 1'b1; g_byte = LCD_DISP_CTRL; nxt = SQ_DISP; end
            SQ_DISP:  if (eng_done) begin go = 1'b1; g_byte = LCD_CLEAR; nxt = SQ_CLR; end
            SQ_CLR:   if (eng_done) begin ld = 1'b1; ld_val = CNT_W'(CLR_CYC); nxt = SQ_CLRW; end
            SQ_CLRW:  if (expired) begin go = 1'b1; g_byte = LCD_ENTRY; nxt = SQ_ENTRY; end
            SQ_ENTRY: if (eng_done) nxt = SQ_IDLE;
            SQ_IDLE: begin
                if (cmd_valid) begin
                    go = 1'b1; g_byte = cmd_byte; g_rs = cmd_is_char; nxt = SQ_BYTE;
                end else if (str_valid) begin
                    ld = 1'b1; ld_val = CNT_W'(LINE_CYC); nxt = SQ_LWAIT;
                end
            end
            SQ_BYTE:  if (eng_done) nxt = SQ_IDLE;
            SQ_LWAIT: if (expired) begin go = 1'b1; g_byte = LCD_SET_ADDR | line_base(line_q); nxt = SQ_LADDR; end
            SQ_LADDR: if (eng_done) nxt = SQ_RUN;
            SQ_RUN:   if (str_valid) begin go = 1'b1; g_byte = str_char; g_rs = 1'b1; nxt = SQ_CHAR; end
            SQ_CHAR:  if (eng_done) nxt = last_q ? SQ_IDLE : SQ_RUN;
            default:  nxt = SQ_IDLE;
        endcase
    end

    // State, captured string context, init and error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SQ_PWR;
            line_q <= 2'd0;
            last_q <= 1'b0;
            init_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            st <= nxt;
            if (st == SQ_IDLE && !cmd_valid && str_valid) line_q <= str_line;
            if (st == SQ_RUN && str_valid)                last_q <= str_last;
            if (st == SQ_ENTRY && eng_done)               init_q <= 1'b1;
            if (eng_busy && req_err)                      err_q  <= 1'b1;
        end
    end

    assign cmd_ready = (st == SQ_IDLE);
    assign str_ready = (st == SQ_RUN);
    assign req_valid = eng_busy;
    assign req_addr  = EXP_ADDR;
    assign init_done = init_q;
    assign err_flag  = err_q;
endmodule

// File: rtl/charlcd_exp_ctrl_chk.sv
// Protocol checker for the expander LCD controller, bound to its top.
module charlcd_exp_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [7:0] req_data,
    input logic       req_done,
    input logic       req_err,
    input logic       init_done,
    input logic       cmd_ready,
    input logic       str_ready,
    input logic       err_flag
);
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_done && !req_err |=> req_valid && $stable(req_data));

    a_r5_rw_low: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !req_data[1]);

    a_r6_bl_init: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !init_done |-> !req_data[3]);

    a_r6_bl_run: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && init_done |-> req_data[3]);

    a_r4_en_pair: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_done && req_data[2] |=>
        req_valid && !req_data[2] && req_data[7:4] == $past(req_data[7:4]));

    a_r10_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ready && str_ready));

    a_r1_ready_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready || str_ready) |-> init_done);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
endmodule

bind charlcd_exp_ctrl charlcd_exp_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
    .req_done(req_done), .req_err(req_err), .init_done(init_done),
    .cmd_ready(cmd_ready), .str_ready(str_ready), .err_flag(err_flag)
);

// File: tb/charlcd_exp_ctrl_test.sv
// Bench: 1 MHz build so one microsecond is one cycle. An I2C master model logs
// every completed frame and its start cycle. Expected frames are computed here.
module charlcd_exp_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int PWR_C  = 400;
    localparam int CLR_C  = 30;
    localparam int LINE_C = 12;
    localparam int LAT    = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_is_char = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       str_valid = 1'b0, str_last = 1'b0;
    logic [1:0] str_line = 2'd0;
    logic [7:0] str_char = 8'h00;
    logic       req_done = 1'b0, req_err = 1'b0;
    logic       cmd_ready, str_ready, req_valid, init_done, err_flag;
    logic [7:0] req_addr, req_data;

    charlcd_exp_ctrl #(.CLK_HZ(1_000_000), .PWR_US(PWR_C), .CLR_US(CLR_C),
                       .LINE_US(LINE_C), .EXP_ADDR(8'h4E)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_byte(cmd_byte), .cmd_is_char(cmd_is_char), .str_valid(str_valid),
        .str_ready(str_ready), .str_line(str_line), .str_char(str_char),
        .str_last(str_last), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_done(req_done), .req_err(req_err),
        .init_done(init_done), .err_flag(err_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    int cyc = 0, rel_cyc = 0;
    int nlog = 0, nexp = 0, lat = 0, cur_start = 0, inject_at = -1;
    logic [7:0] logd [0:4095];
    int         logt [0:4095];
    logic [7:0] expd [0:4095];

    always @(posedge clk) cyc <= cyc + 1;

    // I2C master model: answers after LAT cycles, logs each completed frame
    always @(negedge clk) begin
        if (req_done || req_err) begin
            req_done = 1'b0; req_err = 1'b0; lat = 0;
        end else if (rst_n && req_valid) begin
            if (lat == 0) cur_start = cyc;
            if (lat == LAT) begin
                if (nlog == inject_at) begin
                    req_err = 1'b1; inject_at = -1;
                end else begin
                    req_done = 1'b1; logd[nlog] = req_data; logt[nlog] = cur_start; nlog++;
                end
                lat = 0;
            end else lat++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input int act, input int lim);
        checks++;
        if (act < lim) begin
            errors++;
            $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
        end
    endtask

    function automatic logic [7:0] fr(input int nib, input int en, input int rs, input int bl);
        return 8'(nib * 16 + bl * 8 + en * 4 + rs);
    endfunction

    task automatic push_nib(input int nib, input int rs, input int bl);
        expd[nexp] = fr(nib, 1, rs, bl); nexp++;
        expd[nexp] = fr(nib, 0, rs, bl); nexp++;
    endtask

    task automatic push_byte(input int b, input int rs, input int bl);
        push_nib(b / 16, rs, bl);
        push_nib(b % 16, rs, bl);
    endtask

    task automatic wait_log(input int n);
        while (nlog < n) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic cmp_log(input string req, input int from, input int to);
        for (int i = from; i < to; i++) chk(req, logd[i], expd[i]);
    endtask

    task automatic send_cmd(input int b, input int rs);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_byte = 8'(b); cmd_is_char = rs[0];
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_beat(input int c, input logic last, input logic [1:0] ln);
        str_valid = 1'b1; str_char = 8'(c); str_last = last; str_line = ln;
        while (!str_ready) @(negedge clk);
        @(negedge clk);
        str_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int base, t0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 req_valid", req_valid, 0);
        chk("R1 cmd_ready", cmd_ready, 0);
        chk("R1 str_ready", str_ready, 0);
        chk("R1 init_done", init_done, 0);
        chk("R1 err_flag", err_flag, 0);
        rst_n = 1'b1; rel_cyc = cyc;

        // R2 R4 R5 R6: power-up sequence, backlight off
        push_nib(2, 0, 0);
        push_byte(8'h28, 0, 0);
        push_byte(8'h0C, 0, 0);
        push_byte(8'h01, 0, 0);
        push_byte(8'h06, 0, 0);
        // R1: a byte offered during power-up waits for init_done
        @(negedge clk);
        cmd_valid = 1'b1; cmd_byte = 8'h41; cmd_is_char = 1'b1;
        repeat (PWR_C / 2) @(negedge clk);
        chk("R1 hold cmd_ready", cmd_ready, 0);
        chk("R1 no req during wait", req_valid, 0);
        while (!cmd_ready) @(negedge clk);
        chk("R1 init frames before accept", nlog, 18);
        chk("R2 init_done", init_done, 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmp_log("R2 init frames", 0, 18);
        chk_ge("R1 power-up wait", logt[0] - rel_cyc, PWR_C);
        chk_ge("R2 clear wait", logt[14] - logt[13], CLR_C);
        chk("R7 addr", req_addr, 8'h4E);

        // R3 R5 R6: the held character 0x41 with RS=1, backlight on
        push_byte(8'h41, 1, 1);
        wait_log(nexp);
        chk("R3 char 0x41 frame0", logd[18], 8'h4D);
        chk("R3 char 0x41 frame3", logd[21], 8'h19);
        cmp_log("R6 char frames", 18, 22);

        // R4 R5: sweep every byte as command and as character
        base = nexp;
        for (int rs = 0; rs < 2; rs++) begin
            for (int b = 0; b < 256; b++) begin
                send_cmd(b, rs);
                push_byte(b, rs, 1);
                wait_log(nexp);
            end
        end
        cmp_log("R4 R5 sweep", base, nexp);

        // R8 R10: strings to each line; later line fields are ignored
        for (int ln = 0; ln < 4; ln++) begin
            base = nexp;
            push_byte(128 + (ln % 2) * 64 + (ln / 2) * 20, 0, 1);
            push_byte(8'h30 + ln, 1, 1);
            push_byte(8'h61, 1, 1);
            push_byte(8'h7A, 1, 1);
            @(negedge clk);
            t0 = cyc;
            send_beat(8'h30 + ln, 1'b0, 2'(ln));
            chk("R10 cmd_ready low in string", cmd_ready, 0);
            send_beat(8'h61, 1'b0, 2'(ln + 1));
            send_beat(8'h7A, 1'b1, 2'(ln + 2));
            wait_log(nexp);
            chk_ge("R8 line wait", logt[base] - t0, LINE_C);
            cmp_log("R8 string frames", base, nexp);
            chk("R10 idle after string", cmd_ready, 1);
        end

        // R9: error on the second frame of a byte aborts that byte only
        chk("R9 err_flag clear", err_flag, 0);
        base = nexp;
        inject_at = nexp + 1;
        expd[nexp] = fr(5, 1, 0, 1); nexp++;
        send_cmd(8'h5A, 0);
        repeat (20) @(negedge clk);
        chk("R9 truncated count", nlog, nexp);
        chk("R9 err_flag set", err_flag, 1);
        push_byte(8'hC3, 1, 1);
        send_cmd(8'hC3, 1);
        wait_log(nexp);
        cmp_log("R9 resume frames", base, nexp);
        chk("R9 err_flag sticky", err_flag, 1);
        chk("R7 total frames", nlog, nexp);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule